// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural floating-point register, either a current value or the identity of the station that will produce the next value. When an instruction issues, the table answers two source lookups in the same cycle. Each answer is either a ready value or the tag of the station the consumer must wait on. On the next clock edge the table then records the issuing station's tag as the new producer of the destination register.

Results come back on a single broadcast bus that carries a producer tag and a value. A register takes the value only when the bus tag equals the producer it has on record. A completion from an older producer that has since been superseded therefore never reaches the register. Tag value 0 is reserved to mean "no producer", so station tags run from 1 upward. The default configuration has 8 registers, 64-bit values and 4-bit tags.

Top module: `rename_status_table`

## Requirements
- R1: After a synchronous active-high reset, every register reads as not pending, with tag 0 and value 0.
- R2: A lookup of a register that is not pending returns pending = 0, tag = 0 and the stored value.
- R3: A lookup of a pending register, when the bus does not carry its producer tag, returns pending = 1, the producer tag, and value 0.
- R4: An issue with `iss_valid` = 1 and a nonzero `iss_tag` makes register `iss_dst` pending on `iss_tag` from the next cycle, and leaves its value unchanged. This also applies when the register is already pending on another tag.
- R5: An issue whose tag is 0 changes no register.
- R6: A bus cycle with `bus_valid` = 1 whose tag equals a pending register's producer tag writes `bus_value` into that register and clears its pending state from the next cycle.
- R7: A bus cycle whose tag does not equal a register's recorded producer leaves that register unchanged, including a completion from a producer that was superseded by a later rename.
- R8: When one cycle both renames a register and carries a matching bus tag for it, the rename takes effect. The register stays pending on the new tag and keeps its old value.
- R9: A lookup of a register that is pending on the tag present on the bus in that same cycle returns pending = 0, tag = 0 and `bus_value`.
- R10: Lookups reflect the state before the current cycle's rename, so a source equal to the destination of the same issue sees the previous producer or value. The two lookup ports are independent.
- R11: With `bus_valid` = 0, the bus tag and value have no effect, even when the tag matches a pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe |
| iss_tag | input | 4 | Tag of the issuing station (0 = none) |
| iss_dst | input | 3 | Destination register of the issuing instruction |
| src_a | input | 3 | First source register to look up |
| src_b | input | 3 | Second source register to look up |
| rd_a_pending | output | 1 | First source still waits on a producer |
| rd_a_tag | output | 4 | Producer tag for the first source, 0 when ready |
| rd_a_value | output | 64 | Value of the first source, 0 when pending |
| rd_b_pending | output | 1 | Second source still waits on a producer |
| rd_b_tag | output | 4 | Producer tag for the second source, 0 when ready |
| rd_b_value | output | 64 | Value of the second source, 0 when pending |
| bus_valid | input | 1 | Result broadcast strobe |
| bus_tag | input | 4 | Producer tag of the broadcast result |
| bus_value | input | 64 | Broadcast result value |

## Verification
Every register is renamed with every nonzero tag and then completed. A completion carrying a stale tag is sent before the matching one, which separates tag-qualified writes from writes that ignore the tag. Dedicated patterns cover the remaining cases. Two renames are stacked on one register and completed oldest first, which shows that only the youngest producer lands. A rename and a matching completion arrive in the same cycle, which shows the rename wins. A lookup happens while its producer broadcasts, which shows the bypass. A source equal to the issuing destination shows that lookups use the state before the rename. An issue with tag 0 and a matching tag with the strobe low show that neither touches the table.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    parameter int NUM_REGS = 8;
    parameter int DATA_W   = 64;
    parameter int TAG_W    = 4;
    localparam int IDX_W   = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam tag_t NO_TAG = '0;

    typedef struct packed {
        logic  pending;
        tag_t  tag;
        data_t value;
    } entry_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t value;
    } bcast_t;

    typedef struct packed {
        logic  pending;
        tag_t  tag;
        data_t value;
    } lookup_t;

    function automatic logic bus_hits(entry_t e, bcast_t b);
        return b.valid && e.pending && (e.tag == b.tag);
    endfunction
endpackage

// File: rtl/rrt_entry.sv
module rrt_entry
    import rrt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   iss_valid,
    input  tag_t   iss_tag,
    input  idx_t   iss_dst,
    input  bcast_t bus,
    output entry_t state
);
    localparam idx_t MY_IDX = idx_t'(IDX);

    logic rename;
    logic hit;

    assign rename = iss_valid && (iss_tag != NO_TAG) && (iss_dst == MY_IDX);
    assign hit    = bus_hits(state, bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (rename) begin
            state.pending <= 1'b1;
            state.tag     <= iss_tag;
        end else if (hit) begin
            state.pending <= 1'b0;
            state.tag     <= NO_TAG;
            state.value   <= bus.value;
        end
    end

    // R4 / R8: a rename always lands, even against a matching broadcast
    p_rename_lands_r4: assert property (@(posedge clk) disable iff (rst)
        rename |=> state.pending && state.tag == $past(iss_tag)
                   && state.value == $past(state.value))
        else $error("rename did not take effect");

    // R6: matching broadcast writes and clears
    p_match_writes_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && !rename) |=> !state.pending && state.value == $past(bus.value))
        else $error("matching broadcast not captured");

    // R7 / R11: no rename and no match means no change
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rename && !hit) |=> $stable(state))
        else $error("entry changed without cause");

    // R4 / R5: a pending entry never carries the reserved tag
    p_tag_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        state.pending |-> state.tag != NO_TAG)
        else $error("pending entry with reserved tag");
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
    import rrt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  entry_t [NUM_REGS-1:0]   tbl,
    input  idx_t                    idx,
    input  bcast_t                  bus,
    output lookup_t                 res
);
    entry_t sel;

    assign sel = tbl[idx];

    always_comb begin
        res = '0;
        if (!sel.pending) begin
            res.value = sel.value;
        end else if (bus_hits(sel, bus)) begin
            res.value = bus.value;
        end else begin
            res.pending = 1'b1;
            res.tag     = sel.tag;
        end
    end

    // R3: a waiting answer names a real producer and carries no value
    p_wait_has_tag_r3: assert property (@(posedge clk) disable iff (rst)
        res.pending |-> (res.tag != NO_TAG && res.value == '0))
        else $error("pending lookup malformed");

    // R2 / R9: a ready answer carries the reserved tag
    p_ready_no_tag_r2: assert property (@(posedge clk) disable iff (rst)
        !res.pending |-> res.tag == NO_TAG)
        else $error("ready lookup carries a tag");
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
    import rrt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                iss_valid,
    input  logic [TAG_W-1:0]    iss_tag,
    input  logic [IDX_W-1:0]    iss_dst,
    input  logic [IDX_W-1:0]    src_a,
    input  logic [IDX_W-1:0]    src_b,
    output logic                rd_a_pending,
    output logic [TAG_W-1:0]    rd_a_tag,
    output logic [DATA_W-1:0]   rd_a_value,
    output logic                rd_b_pending,
    output logic [TAG_W-1:0]    rd_b_tag,
    output logic [DATA_W-1:0]   rd_b_value,
    input  logic                bus_valid,
    input  logic [TAG_W-1:0]    bus_tag,
    input  logic [DATA_W-1:0]   bus_value
);
    bcast_t                bus;
    entry_t [NUM_REGS-1:0] tbl;
    lookup_t               res_a;
    lookup_t               res_b;

    assign bus = '{valid: bus_valid, tag: bus_tag, value: bus_value};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        rrt_entry #(.IDX(g)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .iss_valid (iss_valid),
            .iss_tag   (iss_tag),
            .iss_dst   (iss_dst),
            .bus       (bus),
            .state     (tbl[g])
        );
    end

    rrt_lookup u_look_a (
        .clk (clk), .rst (rst), .tbl (tbl), .idx (src_a), .bus (bus), .res (res_a)
    );
    rrt_lookup u_look_b (
        .clk (clk), .rst (rst), .tbl (tbl), .idx (src_b), .bus (bus), .res (res_b)
    );

    assign rd_a_pending = res_a.pending;
    assign rd_a_tag     = res_a.tag;
    assign rd_a_value   = res_a.value;
    assign rd_b_pending = res_b.pending;
    assign rd_b_tag     = res_b.tag;
    assign rd_b_value   = res_b.value;

    // R10: same index on both ports gives the same answer
    p_ports_agree_r10: assert property (@(posedge clk) disable iff (rst)
        (src_a == src_b) |-> (res_a == res_b))
        else $error("lookup ports disagree");

    // R11: a silent bus never clears a pending register
    p_idle_bus_r11: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !iss_valid && tbl[src_a].pending) |=> $stable(tbl[$past(src_a)]))
        else $error("idle bus changed a register");
endmodule

// File: tb/sim_rename_status_table.sv
`timescale 1ns/1ps
module sim_rename_status_table;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        iss_valid;
    logic [3:0]  iss_tag;
    logic [2:0]  iss_dst, src_a, src_b;
    logic        rd_a_pending, rd_b_pending;
    logic [3:0]  rd_a_tag, rd_b_tag;
    logic [63:0] rd_a_value, rd_b_value;
    logic        bus_valid;
    logic [3:0]  bus_tag;
    logic [63:0] bus_value;

    logic [63:0] m_val [NR];
    logic        m_pend[NR];
    logic [3:0]  m_tag [NR];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    rename_status_table u0 (
        .clk, .rst, .iss_valid, .iss_tag, .iss_dst, .src_a, .src_b,
        .rd_a_pending, .rd_a_tag, .rd_a_value,
        .rd_b_pending, .rd_b_tag, .rd_b_value,
        .bus_valid, .bus_tag, .bus_value
    );

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_a(string req, logic p, logic [3:0] t, logic [63:0] v);
        cmp(req, "a.pending", 64'(rd_a_pending), 64'(p));
        cmp(req, "a.tag", 64'(rd_a_tag), 64'(t));
        cmp(req, "a.value", rd_a_value, v);
    endtask

    task automatic check_b(string req, logic p, logic [3:0] t, logic [63:0] v);
        cmp(req, "b.pending", 64'(rd_b_pending), 64'(p));
        cmp(req, "b.tag", 64'(rd_b_tag), 64'(t));
        cmp(req, "b.value", rd_b_value, v);
    endtask

    // expected lookup of register r with the bus idle
    task automatic check_reg(string req, int r);
        src_a = 3'(r);
        src_b = 3'((r + 3) % NR);
        #1;
        check_a(req, m_pend[r], m_pend[r] ? m_tag[r] : 4'd0, m_pend[r] ? 64'd0 : m_val[r]);
        check_b(req, m_pend[(r+3)%NR], m_pend[(r+3)%NR] ? m_tag[(r+3)%NR] : 4'd0,
                m_pend[(r+3)%NR] ? 64'd0 : m_val[(r+3)%NR]);
    endtask

    // commit current inputs at the next edge, apply the requirement rules to the model
    task automatic step();
        @(posedge clk);
        for (int r = 0; r < NR; r++) begin
            if (iss_valid && iss_tag != 0 && iss_dst == 3'(r)) begin
                m_pend[r] = 1'b1;
                m_tag[r]  = iss_tag;
            end else if (bus_valid && m_pend[r] && m_tag[r] == bus_tag) begin
                m_pend[r] = 1'b0;
                m_tag[r]  = 4'd0;
                m_val[r]  = bus_value;
            end
        end
        @(negedge clk);
        iss_valid = 0; bus_valid = 0;
    endtask

    task automatic issue(int r, int t);
        iss_valid = 1; iss_dst = 3'(r); iss_tag = 4'(t);
        step();
    endtask

    task automatic bcast(int t, logic [63:0] v);
        bus_valid = 1; bus_tag = 4'(t); bus_value = v;
        step();
    endtask

    function automatic logic [63:0] pat(int r, int t);
        return {32'(r * 40503 + 7), 32'(t * 2654435 + r)};
    endfunction

    initial begin
        rst = 1; iss_valid = 0; iss_tag = 0; iss_dst = 0;
        src_a = 0; src_b = 0; bus_valid = 0; bus_tag = 0; bus_value = 0;
        for (int r = 0; r < NR; r++) begin
            m_val[r] = 0; m_pend[r] = 0; m_tag[r] = 0;
        end
        @(negedge clk); @(negedge clk);
        rst = 0;

        // R1: reset state
        for (int r = 0; r < NR; r++) check_reg("R1", r);

        // R4 R3 R6 R2: rename then complete every register
        for (int r = 0; r < NR; r++) begin
            issue(r, r + 1);
            check_reg("R4/R3", r);
            bcast(r + 1, pat(r, 0));
            check_reg("R6/R2", r);
        end

        // R5: tag 0 issue ignored
        issue(2, 0);
        check_reg("R5", 2);

        // R7: stacked renames, stale completion ignored
        issue(3, 5);
        issue(3, 9);
        bcast(5, 64'hDEAD_0005);
        check_reg("R7", 3);
        cmp("R7", "r3 still pending", 64'(rd_a_pending), 64'd1);
        bcast(9, 64'hBEEF_0009);
        check_reg("R6", 3);
        cmp("R6", "youngest value", rd_a_value, 64'hBEEF_0009);

        // R8: rename and matching completion in the same cycle
        issue(4, 6);
        iss_valid = 1; iss_dst = 3'd4; iss_tag = 4'd7;
        bus_valid = 1; bus_tag = 4'd6; bus_value = 64'hAAAA_0006;
        step();
        check_reg("R8", 4);
        cmp("R8", "tag new", 64'(rd_a_tag), 64'd7);
        bcast(7, 64'h1234_0007);
        check_reg("R8", 4);

        // R9: bypass of the broadcast into a lookup
        issue(5, 10);
        bus_valid = 1; bus_tag = 4'd10; bus_value = 64'h5555_000A;
        src_a = 3'd5; src_b = 3'd6;
        #1;
        check_a("R9", 1'b0, 4'd0, 64'h5555_000A);
        check_b("R9", m_pend[6], m_tag[6], m_val[6]);
        step();
        check_reg("R9", 5);

        // R10: lookup of the destination in its own issue cycle
        iss_valid = 1; iss_dst = 3'd1; iss_tag = 4'd11;
        src_a = 3'd1; src_b = 3'd1;
        #1;
        check_a("R10", 1'b0, 4'd0, m_val[1]);
        check_b("R10", 1'b0, 4'd0, m_val[1]);
        step();
        check_reg("R10", 1);

        // R11: matching tag with the strobe low
        bus_valid = 0; bus_tag = 4'd11; bus_value = 64'hFFFF_FFFF;
        step();
        check_reg("R11", 1);
        bcast(11, pat(1, 11));

        // sweep: every register with every tag, stale tag first
        for (int t = 1; t < 16; t++) begin
            for (int r = 0; r < NR; r++) begin
                issue(r, t);
                check_reg("R4", r);
                bcast((t == 1) ? 15 : t - 1, pat(r, t + 100));
                check_reg("R7", r);
                bcast(t, pat(r, t));
                check_reg("R6", r);
            end
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule